// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This unit treats a 32-bit word as either two 16-bit halfword lanes or four 8-bit byte lanes and performs a lane-wise addition, subtraction, or an exchange form in which each halfword lane pairs with the opposite half of the second operand. A single lane datapath is reused for every form. A two-bit mode chooses how the lane results are interpreted: wrapping arithmetic with unsigned lane flags, wrapping arithmetic with signed lane flags, unsigned saturation, or unsigned halving.

The arithmetic is combinational. The result and a four-bit lane flag register are captured on the clock edge where `valid_i` is high, so both appear one cycle after the request. The flag register is written only in the two flag-producing modes and keeps its value otherwise, so a later select step can consume flags from an earlier operation.

Top module: `simd_addsub`

## Requirements
- R1: After synchronous reset, `result_o` is 0 and `flags_o` is 0.
- R2: A request with `valid_i` high is reflected on `result_o` and `flags_o` after the next rising edge; while `valid_i` is low both outputs hold.
- R3: `subop_i` = 0 adds the halfword lanes and 3 subtracts them (`op_a` minus `op_b`, lane by lane), each lane wrapping modulo 2^16 in the flag modes.
- R4: `subop_i` = 1 makes the low lane `a[15:0] - b[31:16]` and the high lane `a[31:16] + b[15:0]`; `subop_i` = 2 makes the low lane `a[15:0] + b[31:16]` and the high lane `a[31:16] - b[15:0]`.
- R5: `subop_i` = 4 adds the four byte lanes and 7 subtracts them, each lane wrapping modulo 2^8 in the flag modes.
- R6: In mode 0 (unsigned flags) a halfword lane sets both of its flag bits on carry out of an add or on no borrow in a subtract; low lane drives bits 1:0, high lane bits 3:2. A byte lane k sets bit k under the same carry/no-borrow rule.
- R7: In mode 1 (signed flags) a halfword lane sets both its flag bits when its exact signed result is non-negative; a byte lane sets its bit when result bit 7 is 1 for an add, and when result bit 7 is 0 for a subtract. Results equal mode 0.
- R8: In mode 2 (unsigned saturation) a lane that overflows gives all ones and a lane that underflows gives zero.
- R9: In mode 3 (unsigned halving) each lane result is the lane-width-plus-one sum or difference, borrow kept as the top bit, shifted right by one.
- R10: Modes 2 and 3 leave `flags_o` unchanged.
- R11: `subop_i` values 5 and 6 are ignored: neither `result_o` nor `flags_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| op_a_i | input | 32 | First operand word |
| op_b_i | input | 32 | Second operand word |
| subop_i | input | 3 | Lane operation select |
| mode_i | input | 2 | 0 unsigned flags, 1 signed flags, 2 saturate, 3 halve |
| result_o | output | 32 | Registered result word |
| flags_o | output | 4 | Registered lane flags |

## Verification
Every result and flag is due exactly one edge after the edge that samples `valid_i`, so the bench drives a request on a falling edge, drops `valid_i` on the next falling edge and compares both outputs there, half a period after the capturing edge. Flags expected in saturation, halving and ignored sub-operations are the bench's own copy of the last written flags, so any stray write is seen. A hold check changes the operands with `valid_i` low and samples one cycle later.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    MODE_UFLAG = 2'd0,
    MODE_SFLAG = 2'd1,
    MODE_USAT  = 2'd2,
    MODE_UHALF = 2'd3
  } lane_mode_e;

  localparam logic [2:0] OP_ADD16 = 3'd0;
  localparam logic [2:0] OP_ASX   = 3'd1;
  localparam logic [2:0] OP_SAX   = 3'd2;
  localparam logic [2:0] OP_SUB16 = 3'd3;
  localparam logic [2:0] OP_ADD8  = 3'd4;
  localparam logic [2:0] OP_SUB8  = 3'd7;

  function automatic logic op_is_byte(input logic [2:0] op);
    return (op == OP_ADD8) || (op == OP_SUB8);
  endfunction

  function automatic logic op_is_legal(input logic [2:0] op);
    return (op != 3'd5) && (op != 3'd6);
  endfunction
endpackage

// File: rtl/simd_route.sv
module simd_route #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] op_b,
  input  logic [2:0]          subop,
  output logic [2*HALF_W-1:0] b_half,
  output logic [1:0]          sub_half,
  output logic                sub_byte
);
  import simd_pkg::*;

  logic [HALF_W-1:0] b_lo, b_hi;
  assign b_lo = op_b[HALF_W-1:0];
  assign b_hi = op_b[2*HALF_W-1:HALF_W];

  always_comb begin
    b_half   = op_b;
    sub_half = 2'b00;
    case (subop)
      OP_ASX: begin
        b_half   = {b_lo, b_hi};
        sub_half = 2'b01;
      end
      OP_SAX: begin
        b_half   = {b_lo, b_hi};
        sub_half = 2'b10;
      end
      OP_SUB16: sub_half = 2'b11;
      default:  sub_half = 2'b00;
    endcase
  end

  assign sub_byte = (subop == OP_SUB8);
endmodule

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W         = 16,
  parameter bit BYTE_LANE = 1'b0
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic                 sub,
  input  simd_pkg::lane_mode_e mode,
  output logic [W-1:0]         res,
  output logic                 flag
);
  import simd_pkg::*;

  logic [W:0] wide;
  logic       top_bit;
  logic       sign_wide;
  logic       sflag;

  assign wide      = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
  assign top_bit   = wide[W];
  assign sign_wide = a[W-1] ^ b[W-1] ^ top_bit;

  generate
    if (BYTE_LANE) begin : g_byte_flag
      assign sflag = sub ? ~wide[W-1] : wide[W-1];
    end else begin : g_half_flag
      assign sflag = ~sign_wide;
    end
  endgenerate

  always_comb begin
    res  = wide[W-1:0];
    flag = 1'b0;
    case (mode)
      MODE_UFLAG: flag = sub ? ~top_bit : top_bit;
      MODE_SFLAG: flag = sflag;
      MODE_USAT: begin
        if (top_bit) res = sub ? '0 : '1;
      end
      MODE_UHALF: res = wide[W:1];
      default: res = wide[W-1:0];
    endcase
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [2:0]        subop_i,
  input  logic [1:0]        mode_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o
);
  import simd_pkg::*;

  localparam int HALF_W  = DATA_W / 2;
  localparam int BYTE_W  = DATA_W / 4;
  localparam int N_HALF  = 2;
  localparam int N_BYTE  = 4;
  localparam int HALF_FL = N_BYTE / N_HALF;

  lane_mode_e        mode;
  logic [DATA_W-1:0] b_half;
  logic [1:0]        sub_half;
  logic              sub_byte;
  logic [DATA_W-1:0] half_word, byte_word;
  logic [N_HALF-1:0] half_flag;
  logic [N_BYTE-1:0] byte_flag;
  logic [3:0]        flags_next;
  logic              is_byte, is_legal, flag_mode;

  assign mode      = lane_mode_e'(mode_i);
  assign is_byte   = op_is_byte(subop_i);
  assign is_legal  = op_is_legal(subop_i);
  assign flag_mode = (mode == MODE_UFLAG) || (mode == MODE_SFLAG);

  simd_route #(.HALF_W(HALF_W)) u_route (
    .op_b     (op_b_i),
    .subop    (subop_i),
    .b_half   (b_half),
    .sub_half (sub_half),
    .sub_byte (sub_byte)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    simd_lane #(.W(HALF_W), .BYTE_LANE(1'b0)) u_lane (
      .a    (op_a_i[h*HALF_W +: HALF_W]),
      .b    (b_half[h*HALF_W +: HALF_W]),
      .sub  (sub_half[h]),
      .mode (mode),
      .res  (half_word[h*HALF_W +: HALF_W]),
      .flag (half_flag[h])
    );
  end

  for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
    simd_lane #(.W(BYTE_W), .BYTE_LANE(1'b1)) u_lane (
      .a    (op_a_i[k*BYTE_W +: BYTE_W]),
      .b    (op_b_i[k*BYTE_W +: BYTE_W]),
      .sub  (sub_byte),
      .mode (mode),
      .res  (byte_word[k*BYTE_W +: BYTE_W]),
      .flag (byte_flag[k])
    );
  end

  always_comb begin
    if (is_byte) begin
      flags_next = byte_flag;
    end else begin
      for (int f = 0; f < 4; f++) flags_next[f] = half_flag[f / HALF_FL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
    end else if (valid_i && is_legal) begin
      result_o <= is_byte ? byte_word : half_word;
      if (flag_mode) flags_o <= flags_next;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(result_o) && $stable(flags_o))); // R2

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !flag_mode) |=> $stable(flags_o)); // R10

  AST_BAD_OP: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !is_legal) |=> ($stable(result_o) && $stable(flags_o))); // R11

  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (rst)
    (valid_i && is_legal && !is_byte && flag_mode)
      |=> ((flags_o[1] == flags_o[0]) && (flags_o[3] == flags_o[2]))); // R6

  AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode == MODE_USAT && subop_i == OP_SUB16)
      |=> (result_o[HALF_W-1:0] <= $past(op_a_i[HALF_W-1:0]))); // R8

  AST_SAT_CEIL: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode == MODE_USAT && subop_i == OP_ADD16)
      |=> (result_o[HALF_W-1:0] >= $past(op_a_i[HALF_W-1:0]))); // R8
endmodule

// File: tb/simd_addsub_bench.sv
module simd_addsub_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [31:0] op_a_i, op_b_i;
  logic [2:0]  subop_i;
  logic [1:0]  mode_i;
  logic [31:0] result_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] flag_model;
  logic [31:0] res_model;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  simd_addsub u_simd_addsub (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .subop_i(subop_i), .mode_i(mode_i), .result_o(result_o), .flags_o(flags_o)
  );

  function automatic logic [31:0] corner(input int i);
    case (i % 8)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_8000;
      3: return 32'h7FFF_7FFF;
      4: return 32'h8080_8080;
      5: return 32'h7F7F_7F7F;
      6: return 32'h0001_0001;
      default: return 32'h00FF_FF00;
    endcase
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // One lane of the arithmetic model, with integers; w is 8 or 16.
  function automatic void lane_model(input int w, input int x, input int y, input bit sub,
                                     input int mode, input bit byte_lane,
                                     output int r, output bit f);
    int full = (1 << w) - 1;
    int d    = sub ? x - y : x + y;
    int sx   = (x >= (1 << (w-1))) ? x - (1 << w) : x;
    int sy   = (y >= (1 << (w-1))) ? y - (1 << w) : y;
    int sd   = sub ? sx - sy : sx + sy;
    f = 1'b0;
    r = d & full;
    case (mode)
      0: f = sub ? (d >= 0) : (d > full);
      1: begin
        if (byte_lane) f = sub ? (((r >> 7) & 1) == 0) : (((r >> 7) & 1) == 1);
        else           f = (sd >= 0);
      end
      2: r = (d < 0) ? 0 : ((d > full) ? full : d);
      default: r = (d >>> 1) & full;
    endcase
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b,
                       input int op, input int mode);
    int r; bit f;
    int ah[2], bh[2];
    bit sh[2];
    if (op == 5 || op == 6) return;
    if (op == 4 || op == 7) begin
      for (int k = 0; k < 4; k++) begin
        lane_model(8, int'(a[k*8 +: 8]), int'(b[k*8 +: 8]), op == 7, mode, 1'b1, r, f);
        res_model[k*8 +: 8] = r[7:0];
        if (mode < 2) flag_model[k] = f;
      end
    end else begin
      ah[0] = int'(a[15:0]); ah[1] = int'(a[31:16]);
      case (op)
        1: begin bh[0] = int'(b[31:16]); bh[1] = int'(b[15:0]); sh[0] = 1; sh[1] = 0; end
        2: begin bh[0] = int'(b[31:16]); bh[1] = int'(b[15:0]); sh[0] = 0; sh[1] = 1; end
        3: begin bh[0] = int'(b[15:0]); bh[1] = int'(b[31:16]); sh[0] = 1; sh[1] = 1; end
        default: begin bh[0] = int'(b[15:0]); bh[1] = int'(b[31:16]); sh[0] = 0; sh[1] = 0; end
      endcase
      for (int h = 0; h < 2; h++) begin
        lane_model(16, ah[h], bh[h], sh[h], mode, 1'b0, r, f);
        res_model[h*16 +: 16] = r[15:0];
        if (mode < 2) begin
          flag_model[2*h]   = f;
          flag_model[2*h+1] = f;
        end
      end
    end
  endtask

  function automatic string req_of(input int op, input int mode);
    if (op == 5 || op == 6) return "R11";
    if (mode == 2) return "R8";
    if (mode == 3) return "R9";
    if (mode == 1) return "R7";
    if (op == 1 || op == 2) return "R4";
    if (op == 4 || op == 7) return "R5";
    return "R3";
  endfunction

  task automatic compare(input string req);
    checks++;
    if (result_o !== res_model) begin
      errors++;
      $display("FAIL %s result actual %h expected %h", req, result_o, res_model);
    end
    checks++;
    if (flags_o !== flag_model) begin
      errors++;
      $display("FAIL %s flags actual %b expected %b (R6/R10)", req, flags_o, flag_model);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input int op, input int mode);
    @(negedge clk);
    op_a_i = a; op_b_i = b; subop_i = 3'(op); mode_i = 2'(mode); valid_i = 1'b1;
    model(a, b, op, mode);
    @(negedge clk);
    valid_i = 1'b0;
    compare(req_of(op, mode));
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    rst = 1'b1; valid_i = 1'b0; op_a_i = '0; op_b_i = '0; subop_i = '0; mode_i = '0;
    res_model = '0; flag_model = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R1");

    // Directed corners
    apply(32'hFFFF_0001, 32'h0001_0001, 0, 0);  // R6 lane 1 carry
    apply(32'h0000_0005, 32'h0001_0003, 3, 0);  // R6 lane 1 borrow
    apply(32'h7FFF_8000, 32'h0001_0001, 0, 1);  // R7 signed sign
    apply(32'h0010_0001, 32'h0002_0005, 1, 0);  // R4 exchange
    apply(32'hFF00_0000, 32'h0101_FFFF, 4, 2);  // R8 byte saturate
    apply(32'h0000_0000, 32'hFFFF_FFFF, 3, 3);  // R9 halving borrow
    apply(32'h1234_5678, 32'h1111_1111, 5, 0);  // R11
    apply(32'h1234_5678, 32'h1111_1111, 6, 1);  // R11

    // Sweep: every mode and sub-operation over corner and pseudo-random words
    for (int p = 0; p < 24; p++) begin
      if (p < 8) begin a = corner(p); b = corner(p * 3 + 1); end
      else begin seed = next_rand(seed); a = seed; seed = next_rand(seed); b = seed; end
      for (int m = 0; m < 4; m++)
        for (int op = 0; op < 8; op++)
          apply(a, b, op, m);
    end

    // R2: operands change with valid low; outputs hold
    @(negedge clk);
    op_a_i = 32'hDEAD_BEEF; op_b_i = 32'h0BAD_F00D; subop_i = 3'd4; mode_i = 2'd0;
    @(negedge clk);
    @(negedge clk);
    compare("R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule